// File: doc/BRIEF.md
# Oversampling Serial Receiver with Fill-Level Flow Control

This block receives asynchronous serial characters on a single input line. It samples the line sixteen times per bit and takes each bit as the majority of the three samples around the middle of the bit. The frame format is set by configuration inputs:

- 7 or 8 data bits, least significant bit first;
- one of five parity rules;
- one or two stop bits.

For each character the block checks the parity bit and the stop bits. It stores the character, together with a parity-error flag and a framing-error flag, in an on-chip queue. A consumer drains the queue through a valid/ready read port.

When flow control is enabled, an active-low request-to-send output follows the queue fill level. The output goes inactive when the level climbs to a high mark, which tells the far end to pause. It becomes active again only after the level drops below a lower mark, so the output does not toggle around one threshold.

A character that completes while the queue is full is discarded, and a sticky overrun flag records the loss.

Top module: `uart_rx_flow`

## Requirements
- R1: One oversample tick occurs every cfg_div+1 clock cycles, and each bit lasts 16 ticks. A bit's value is the majority of samples 7, 8 and 9, counted from 0 at the tick that detected the start edge. A pulse one sample wide at the bit centre therefore does not change the bit.
- R2: A start bit that the mid-bit majority vote reads as high is treated as a glitch. It produces no character, and the receiver goes back to waiting for a falling edge.
- R3: cfg_eight=1 selects 8 data bits and cfg_eight=0 selects 7 data bits. Data arrives LSB first. A 7-bit character is stored with bit 7 cleared. cfg_two_stop=1 selects two stop bits.
- R4: cfg_par selects the parity rule: 0 none, 1 odd, 2 even, 3 mark (bit always 1), 4 space (bit always 0). The parity bit follows the last data bit and is absent for rule 0. The stored perr flag is 1 exactly when the received parity bit differs from the bit the rule requires for the stored data.
- R5: If any expected stop bit is sampled low, the stored ferr flag is 1. After a framing error the receiver waits for the line to return high before it looks for the next start bit.
- R6: The queue holds DEPTH entries and delivers them in arrival order. rd_valid is 1 whenever the queue is non-empty. An entry is removed on a cycle with rd_valid and rd_ready both high. While the head entry is offered but not accepted, it stays unchanged.
- R7: A character that completes while the queue holds DEPTH entries is dropped. overrun then goes to 1 and stays at 1 until reset.
- R8: With cfg_flow_en=1, rts_n goes to 1 once the fill level is at least HI_MARK, and returns to 0 once the level is below LO_MARK. Between the two marks it keeps its previous value. It updates one cycle after the level changes.
- R9: With cfg_flow_en=0, rts_n is 0 from the next cycle on, whatever the fill level.
- R10: While rst is high, the queue empties, and rts_n and overrun both go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_div | input | DIV_W | Clock cycles per oversample tick, minus one |
| cfg_eight | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_two_stop | input | 1 | 1 = two stop bits expected |
| cfg_par | input | 3 | Parity rule: 0 none, 1 odd, 2 even, 3 mark, 4 space |
| cfg_flow_en | input | 1 | Enables fill-level control of rts_n |
| rd_valid | output | 1 | Queue head is available |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Parity error flag of the head character |
| rd_ferr | output | 1 | Framing error flag of the head character |
| overrun | output | 1 | Sticky flag: a character was dropped because the queue was full |
| rts_n | output | 1 | Active-low request to send |

## Verification
The bench builds the block with DEPTH=16, HI_MARK=14 and LO_MARK=12, and keeps the 16-sample oversampling. With these values the high mark, the hysteresis band, a full queue and the overrun drop can all be reached within a few dozen characters. The test characters run with cfg_div values of 0, 1 and 2, which moves the majority-vote window across different tick rates. At cfg_div=0 one sample equals one clock, so the bench can place one-clock glitches on an exact sample, both inside a data bit and on the start bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic      eight;
        logic      two_stop;
        par_mode_e par;
    } rx_cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_entry_t;

    function automatic logic has_parity(input par_mode_e m);
        return (m == PAR_ODD) || (m == PAR_EVEN) || (m == PAR_MARK) || (m == PAR_SPACE);
    endfunction

    function automatic logic wanted_parity(input logic [7:0] d, input par_mode_e m);
        logic r;
        case (m)
            PAR_ODD:  r = ~(^d);
            PAR_EVEN: r = ^d;
            PAR_MARK: r = 1'b1;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rxd,
    input  logic      tick,
    input  rx_cfg_t   cfg,
    output logic      out_valid,
    output rx_entry_t out_entry
);
    localparam int OVS_W = $clog2(OVS);
    localparam int MID   = OVS / 2;
    localparam logic [OVS_W-1:0] S_A   = OVS_W'(MID - 1);
    localparam logic [OVS_W-1:0] S_B   = OVS_W'(MID);
    localparam logic [OVS_W-1:0] S_V   = OVS_W'(MID + 1);
    localparam logic [OVS_W-1:0] S_END = OVS_W'(OVS - 1);

    logic             sync_q, rxs;
    rx_state_e        st;
    logic [OVS_W-1:0] scnt;
    logic [2:0]       bidx;
    logic [7:0]       shreg;
    logic             v_a, v_b, par_bit, ferr_acc;
    rx_cfg_t          cfg_l;

    logic       vote, last_bit, done_now;
    logic [7:0] fin_data;
    logic       fin_perr, fin_ferr;

    // two-flop synchroniser on the serial line
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b1;
            rxs    <= 1'b1;
        end else begin
            sync_q <= rxd;
            rxs    <= sync_q;
        end
    end

    always_comb begin
        vote     = (v_a & v_b) | (v_a & rxs) | (v_b & rxs);
        last_bit = cfg_l.eight ? (bidx == 3'd7) : (bidx == 3'd6);
        done_now = tick && (scnt == S_V) &&
                   ((st == ST_STOP2) || ((st == ST_STOP1) && !cfg_l.two_stop));
        fin_data = cfg_l.eight ? shreg : {1'b0, shreg[7:1]};
        fin_perr = has_parity(cfg_l.par) && (par_bit != wanted_parity(fin_data, cfg_l.par));
        fin_ferr = ferr_acc | ~vote;
    end

    always_ff @(posedge clk) begin
        out_valid <= 1'b0;
        if (rst) begin
            st        <= ST_IDLE;
            scnt      <= '0;
            bidx      <= '0;
            shreg     <= '0;
            v_a       <= 1'b1;
            v_b       <= 1'b1;
            par_bit   <= 1'b0;
            ferr_acc  <= 1'b0;
            cfg_l     <= '0;
            out_entry <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (tick && !rxs) begin
                        st       <= ST_START;
                        scnt     <= '0;
                        ferr_acc <= 1'b0;
                        cfg_l    <= cfg;
                    end
                end
                ST_HOLD: begin
                    if (rxs) st <= ST_IDLE;
                end
                default: begin
                    if (tick) begin
                        scnt <= (scnt == S_END) ? '0 : scnt + 1'b1;
                        if (scnt == S_A) v_a <= rxs;
                        if (scnt == S_B) v_b <= rxs;
                        if (scnt == S_V) begin
                            case (st)
                                ST_START: if (vote) st <= ST_IDLE;
                                ST_DATA:  shreg <= {vote, shreg[7:1]};
                                ST_PAR:   par_bit <= vote;
                                ST_STOP1: if (cfg_l.two_stop) ferr_acc <= ~vote;
                                default: ;
                            endcase
                        end
                        if (scnt == S_END) begin
                            case (st)
                                ST_START: begin
                                    st   <= ST_DATA;
                                    bidx <= '0;
                                end
                                ST_DATA: begin
                                    if (last_bit) begin
                                        st <= has_parity(cfg_l.par) ? ST_PAR : ST_STOP1;
                                    end else begin
                                        bidx <= bidx + 1'b1;
                                    end
                                end
                                ST_PAR:   st <= ST_STOP1;
                                ST_STOP1: st <= ST_STOP2;
                                default: ;
                            endcase
                        end
                    end
                end
            endcase
            if (done_now) begin
                out_valid      <= 1'b1;
                out_entry.data <= fin_data;
                out_entry.perr <= fin_perr;
                out_entry.ferr <= fin_ferr;
                st             <= fin_ferr ? ST_HOLD : ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  rx_entry_t                  push_entry,
    input  logic                       pop,
    output logic                       not_empty,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_L = CW'(DEPTH);

    rx_entry_t         mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              full, do_wr, do_rd;

    assign full      = (level == FULL_L);
    assign not_empty = (level != '0);
    assign do_wr     = push && !full;
    assign do_rd     = pop && not_empty;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            if (do_wr && !do_rd)      level <= level + 1'b1;
            else if (do_rd && !do_wr) level <= level - 1'b1;
            if (push && full) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts #(
    parameter int CW      = 9,
    parameter int HI_MARK = 238,
    parameter int LO_MARK = 224
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flow_en,
    input  logic [CW-1:0] level,
    output logic          rts_n
);
    localparam logic [CW-1:0] HI_L = CW'(HI_MARK);
    localparam logic [CW-1:0] LO_L = CW'(LO_MARK);

    always_ff @(posedge clk) begin
        if (rst || !flow_en) begin
            rts_n <= 1'b0;
        end else if (level >= HI_L) begin
            rts_n <= 1'b1;
        end else if (level < LO_L) begin
            rts_n <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow
    import uart_rx_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int OVS     = 16,
    parameter int DIV_W   = 16,
    parameter int HI_MARK = 238,
    parameter int LO_MARK = 224
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_eight,
    input  logic             cfg_two_stop,
    input  logic [2:0]       cfg_par,
    input  logic             cfg_flow_en,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             rd_perr,
    output logic             rd_ferr,
    output logic             overrun,
    output logic             rts_n
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          tick, frm_valid;
    rx_entry_t     frm_entry, head;
    rx_cfg_t       cfg;
    logic [CW-1:0] fill_level;

    assign cfg.eight    = cfg_eight;
    assign cfg.two_stop = cfg_two_stop;
    assign cfg.par      = par_mode_e'(cfg_par);

    uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .div(cfg_div), .tick(tick)
    );

    uart_rx_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst(rst), .rxd(rxd), .tick(tick), .cfg(cfg),
        .out_valid(frm_valid), .out_entry(frm_entry)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(frm_valid), .push_entry(frm_entry),
        .pop(rd_ready), .not_empty(rd_valid), .head(head),
        .level(fill_level), .overrun(overrun)
    );

    uart_rx_rts #(.CW(CW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_rts (
        .clk(clk), .rst(rst), .flow_en(cfg_flow_en), .level(fill_level), .rts_n(rts_n)
    );

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;
endmodule

// File: rtl/uart_rx_flow_chk.sv
module uart_rx_flow_chk #(
    parameter int DEPTH   = 256,
    parameter int HI_MARK = 238,
    parameter int LO_MARK = 224,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_flow_en,
    input logic [CW-1:0] level,
    input logic          rts_n,
    input logic          overrun,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [7:0]    rd_data,
    input logic          rd_perr,
    input logic          rd_ferr
);
    localparam logic [CW-1:0] FULL_L = CW'(DEPTH);
    localparam logic [CW-1:0] HI_L   = CW'(HI_MARK);
    localparam logic [CW-1:0] LO_L   = CW'(LO_MARK);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_L);

    p_head_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_perr) && $stable(rd_ferr)));

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    p_rts_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rts_n) |-> ($past(cfg_flow_en) && ($past(level) >= HI_L)));

    p_rts_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rts_n) |-> (!$past(cfg_flow_en) || ($past(level) < LO_L)));

    p_flow_off_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_flow_en |=> !rts_n);
endmodule

bind uart_rx_flow uart_rx_flow_chk #(
    .DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)
) u_chk (
    .clk(clk), .rst(rst), .cfg_flow_en(cfg_flow_en), .level(fill_level),
    .rts_n(rts_n), .overrun(overrun), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr)
);

// File: tb/tb_uart_rx_flow.sv
`timescale 1ns/1ps
module tb_uart_rx_flow;
    localparam int DEPTH = 16;
    localparam int HI    = 14;
    localparam int LO    = 12;

    logic        clk = 1'b0;
    logic        rst, rxd, cfg_eight, cfg_two_stop, cfg_flow_en, rd_ready;
    logic [15:0] cfg_div;
    logic [2:0]  cfg_par;
    logic        rd_valid, rd_perr, rd_ferr, overrun, rts_n;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    uart_rx_flow #(.DEPTH(DEPTH), .OVS(16), .DIV_W(16), .HI_MARK(HI), .LO_MARK(LO)) dut (
        .clk(clk), .rst(rst), .rxd(rxd), .cfg_div(cfg_div), .cfg_eight(cfg_eight),
        .cfg_two_stop(cfg_two_stop), .cfg_par(cfg_par), .cfg_flow_en(cfg_flow_en),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .overrun(overrun), .rts_n(rts_n)
    );

    typedef struct packed {
        logic [1:0] div;
        logic       eight;
        logic       two;
        logic [2:0] rxpar;
        logic [2:0] txpar;
        logic [1:0] stops;
        logic [7:0] data;
    } vec_t;

    // parity codes: 0 none, 1 odd, 2 even, 3 mark, 4 space
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 1'b0, 3'd0, 3'd0, 2'b11, 8'h55},
        '{2'd0, 1'b1, 1'b0, 3'd2, 3'd2, 2'b11, 8'hA7},
        '{2'd0, 1'b1, 1'b0, 3'd2, 3'd1, 2'b11, 8'h3C},
        '{2'd0, 1'b0, 1'b0, 3'd1, 3'd1, 2'b11, 8'h7F},
        '{2'd0, 1'b0, 1'b1, 3'd3, 3'd3, 2'b11, 8'h12},
        '{2'd0, 1'b1, 1'b1, 3'd4, 3'd3, 2'b11, 8'hF0},
        '{2'd0, 1'b1, 1'b0, 3'd0, 3'd0, 2'b00, 8'h96},
        '{2'd0, 1'b1, 1'b1, 3'd1, 3'd1, 2'b01, 8'h69},
        '{2'd1, 1'b1, 1'b0, 3'd2, 3'd2, 2'b11, 8'hC3},
        '{2'd1, 1'b0, 1'b1, 3'd4, 3'd4, 2'b11, 8'hC5},
        '{2'd0, 1'b1, 1'b0, 3'd3, 3'd4, 2'b11, 8'h00},
        '{2'd2, 1'b1, 1'b1, 3'd0, 3'd0, 2'b11, 8'h81}
    };

    logic [7:0] model [64];
    int         m_wr = 0;
    int         m_rd = 0;

    function automatic logic par_of(input logic [7:0] d, input logic [2:0] mode);
        case (mode)
            3'd1:    return ~(^d);
            3'd2:    return ^d;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input int per, input bit glitch);
        for (int c = 0; c < per; c++) begin
            @(negedge clk);
            rxd = (glitch && c == 9) ? ~b : b;
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic eight, input logic two,
                              input logic [2:0] rxpar, input logic [2:0] txpar,
                              input logic [1:0] stops, input int div, input int gbit);
        int per = 16 * (div + 1);
        logic [7:0] dm = eight ? d : {1'b0, d[6:0]};
        drive_bit(1'b0, per, gbit == 0);
        for (int i = 0; i < (eight ? 8 : 7); i++) drive_bit(d[i], per, gbit == i + 1);
        if (rxpar != 3'd0) drive_bit(par_of(dm, txpar), per, 1'b0);
        drive_bit(stops[0], per, 1'b0);
        if (two) drive_bit(stops[1], per, 1'b0);
        @(negedge clk);
        rxd = 1'b1;
        repeat (2 * per) @(negedge clk);
    endtask

    task automatic pop_one;
        @(negedge clk);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        @(negedge clk);
    endtask

    task automatic push8(input logic [7:0] d);
        send_frame(d, 1'b1, 1'b0, 3'd0, 3'd0, 2'b11, 0, -1);
        model[m_wr % 64] = d;
        m_wr++;
    endtask

    task automatic pop_model(input string req);
        chk(rd_valid && rd_data == model[m_rd % 64], req, {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, model[m_rd % 64]});
        m_rd++;
        pop_one();
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; rxd = 1'b1; rd_ready = 1'b0;
        cfg_div = 16'd0; cfg_eight = 1'b1; cfg_two_stop = 1'b0; cfg_par = 3'd0; cfg_flow_en = 1'b0;
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(!rd_valid, "R10 rd_valid", {31'd0, rd_valid}, 0);
        chk(!rts_n, "R10 rts_n", {31'd0, rts_n}, 0);
        chk(!overrun, "R10 overrun", {31'd0, overrun}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // table walk: R3 formats, R4 parity rules, R5 stop checking, R1 tick rates
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            logic [7:0] ed;
            logic ep, ef;
            string req;
            cfg_div = {14'd0, t.div}; cfg_eight = t.eight; cfg_two_stop = t.two; cfg_par = t.rxpar;
            send_frame(t.data, t.eight, t.two, t.rxpar, t.txpar, t.stops, int'(t.div), -1);
            ed = t.eight ? t.data : {1'b0, t.data[6:0]};
            ep = (t.rxpar != 3'd0) && (par_of(ed, t.txpar) != par_of(ed, t.rxpar));
            ef = !t.stops[0] || (t.two && !t.stops[1]);
            req = ef ? "R5 frame" : (ep ? "R4 parity" : "R3 format");
            chk({rd_valid, rd_data, rd_perr, rd_ferr} == {1'b1, ed, ep, ef}, req,
                {21'd0, rd_valid, rd_data, rd_perr, rd_ferr}, {21'd0, 1'b1, ed, ep, ef});
            repeat (4) @(negedge clk);
            chk(rd_valid && rd_data == ed, "R6 head held", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, ed});
            pop_one();
            chk(!rd_valid, "R6 popped", {31'd0, rd_valid}, 0);
        end

        // R2: short low pulse is not a start bit
        cfg_div = 16'd0; cfg_eight = 1'b1; cfg_two_stop = 1'b0; cfg_par = 3'd0;
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
        chk(!rd_valid, "R2 glitch rejected", {31'd0, rd_valid}, 0);
        send_frame(8'h5A, 1'b1, 1'b0, 3'd0, 3'd0, 2'b11, 0, -1);
        chk(rd_valid && rd_data == 8'h5A, "R2 recovery", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, 8'h5A});
        pop_one();

        // R1: single-sample glitch at bit centre is outvoted
        send_frame(8'hC6, 1'b1, 1'b0, 3'd0, 3'd0, 2'b11, 0, 3);
        chk(rd_valid && rd_data == 8'hC6 && !rd_ferr, "R1 data glitch", {22'd0, rd_valid, rd_data, rd_ferr}, {22'd0, 1'b1, 8'hC6, 1'b0});
        pop_one();
        send_frame(8'h3B, 1'b1, 1'b0, 3'd0, 3'd0, 2'b11, 0, 0);
        chk(rd_valid && rd_data == 8'h3B, "R1 start glitch", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, 8'h3B});
        pop_one();

        // R8/R9: watermark with hysteresis
        cfg_flow_en = 1'b1;
        for (int i = 0; i < 13; i++) push8(8'h10 + 8'(i));
        chk(!rts_n, "R8 below high mark", {31'd0, rts_n}, 0);
        push8(8'h1D);
        chk(rts_n, "R8 at high mark", {31'd0, rts_n}, 1);
        pop_model("R6 order");
        chk(rts_n, "R8 hysteresis 13", {31'd0, rts_n}, 1);
        pop_model("R6 order");
        chk(rts_n, "R8 hysteresis 12", {31'd0, rts_n}, 1);
        pop_model("R6 order");
        chk(!rts_n, "R8 below low mark", {31'd0, rts_n}, 0);
        for (int i = 0; i < 3; i++) push8(8'h40 + 8'(i));
        chk(rts_n, "R8 refill", {31'd0, rts_n}, 1);
        cfg_flow_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(!rts_n, "R9 flow off", {31'd0, rts_n}, 0);
        cfg_flow_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(rts_n, "R8 flow back on", {31'd0, rts_n}, 1);

        // R7: fill to DEPTH then one more
        push8(8'h50);
        push8(8'h51);
        chk(!overrun, "R7 no overrun at full", {31'd0, overrun}, 0);
        send_frame(8'hEE, 1'b1, 1'b0, 3'd0, 3'd0, 2'b11, 0, -1);
        chk(overrun, "R7 overrun set", {31'd0, overrun}, 1);
        while (m_rd < m_wr) pop_model("R7 drain order");
        chk(!rd_valid, "R7 dropped byte absent", {31'd0, rd_valid}, 0);
        chk(overrun, "R7 sticky", {31'd0, overrun}, 1);
        chk(!rts_n, "R8 drained", {31'd0, rts_n}, 0);

        // R10: reset clears sticky state
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!overrun && !rd_valid && !rts_n, "R10 mid-run reset", {29'd0, overrun, rd_valid, rts_n}, 0);

        finish_run();
    end
endmodule